// File: doc/BRIEF.md
# Quad DAC Host Write Controller

This block sits next to a host and drives the digital pins of an external double-buffered quad 12-bit DAC. The host hands it one request at a time on a valid/ready handshake: a channel number, a 12-bit code, and a flag that says whether the outputs should change now. The controller turns each request into a 16-bit serial frame and then pulses the register-load strobe so that the chosen channel's input register takes the code. When the flag is set, it follows with a strobe that moves all four input registers into the output registers together. Writes sent with the flag clear are therefore held until a later write sets it, so up to four channels can change in the same instant.

A second command on the same handshake resets the converter. It carries a choice between mid-scale (800h) and zero-scale (000h). The controller sets the select line first, waits out its setup time, and then drives a reset pulse. Every minimum time on the serial pins is converted from nanoseconds into whole system-clock cycles from a clock-period parameter. Each conversion rounds up and never gives less than one cycle.

Top module: `qdac_host_ctrl`

## Requirements
- R1: After reset the chip select, serial clock, register-load, update-all and reset lines are all high and `req_ready` is high; these five lines are high whenever `req_ready` is high.
- R2: Each write sends exactly 16 bits, most significant first, sampled on rising serial clock edges while chip select is low: channel bit 1, channel bit 0, two zero pad bits, then code bits 11 down to 0.
- R3: Serial data changes only while the serial clock is low. Each low phase lasts at least ceil(max(50,25)/P) cycles, each high phase at least ceil(max(30,20)/P) cycles, and data is steady for at least ceil(25/P) cycles before each rise (P is the clock period in ns).
- R4: Chip select falls at least ceil(55/P) cycles before the first rise. It rises only while the serial clock is high, at least ceil(15/P) cycles after the last rise.
- R5: The register-load line goes low only while chip select and serial clock are both high, and the serial clock never moves while it is low. It falls at least ceil(15/P) cycles after the last rise, stays low at least ceil(45/P) cycles, and is high at least ceil(40/P) cycles before any serial clock rise.
- R6: A write with `req_update` = 0 loads only the addressed input register: no update-all pulse occurs and the converter outputs keep their values.
- R7: A write with `req_update` = 1 is followed by exactly one update-all low pulse of at least ceil(45/P) cycles, during which the other strobes and chip select are high. At that pulse every channel takes the last code written to it.
- R8: A reset command drives `dac_rstsel` to `rst_cmd_mid` (1 = 800h, 0 = 000h) at least ceil(25/P) cycles before `dac_rst_n` falls, holds it steady while reset is low, and keeps reset low for at least ceil(70/P) cycles. All input and output registers then hold the chosen code.
- R9: Once a request or command is accepted, `req_ready` is low on the next cycle. If both are valid in the same cycle, the reset command is taken first.
- R10: `req_ready` returns high no sooner than ceil(max(45,40)/P) cycles after the final strobe of the operation rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Controller idle and able to accept a request or command |
| req_chan | input | 2 | Target channel of the write |
| req_code | input | 12 | Code to write |
| req_update | input | 1 | 1: update all outputs after this write |
| rst_cmd_valid | input | 1 | Converter reset command valid (shares `req_ready`) |
| rst_cmd_mid | input | 1 | 1: reset to mid-scale, 0: reset to zero-scale |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdi | output | 1 | Serial data |
| dac_ldreg_n | output | 1 | Input register load strobe, active low |
| dac_lddacs_n | output | 1 | Update-all strobe, active low |
| dac_rst_n | output | 1 | Converter reset, active low |
| dac_rstsel | output | 1 | Reset code select, 1 = mid-scale |

## Verification
The bench builds the block with its default timing parameters and a 20 ns clock period. At that period the data-hold, clock-to-select and clock-to-strobe times round up to a single cycle, while the first low phase, register-load width and reset width round up to three or four cycles. This makes every max() choice between competing setup windows visible, and the bench can catch a phase that is one cycle short. A pin-level model decodes each frame, fills input registers on the register-load fall and copies them to the outputs on the update-all fall. It compares them with codes predicted from the request stream, including four-channel batches and resets to both scales.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_LDREG,
    ST_LDDACS,
    ST_SEL,
    ST_RST,
    ST_REC
  } qdac_state_e;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int cyc_of(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qdac_fmt.sv
module qdac_fmt #(
  parameter int ADDR_W = 2,
  parameter int PAD_W  = 2,
  parameter int CODE_W = 12,
  localparam int WORD_W = ADDR_W + PAD_W + CODE_W
) (
  input  logic [ADDR_W-1:0] chan,
  input  logic [CODE_W-1:0] code,
  output logic [WORD_W-1:0] word
);

  // channel first, zero pad, then the code, MSB first on the wire
  assign word = {chan, {PAD_W{1'b0}}, code};

endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              shift,
  output logic              msb
);

  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_d;
  logic              sr_en;

  assign sr_en = load | shift;

  always_comb begin
    if (load) sr_d = din;
    else      sr_d = {sr_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign msb = sr_q[WORD_W-1];

endmodule

// File: rtl/qdac_timer.sv
module qdac_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/qdac_seq.sv
module qdac_seq
  import qdac_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CNT_W   = 4,
  parameter int LOW0_C  = 3,
  parameter int LOW_C   = 3,
  parameter int HIGH_C  = 2,
  parameter int HIGHL_C = 2,
  parameter int LDRW_C  = 3,
  parameter int LDDW_C  = 3,
  parameter int RSSH_C  = 2,
  parameter int RSTW_C  = 4,
  parameter int REC_C   = 3,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_update,
  input  logic             cmd_valid,
  input  logic             cmd_mid,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_shift,
  output logic             ready,
  output logic             cs_n,
  output logic             sclk,
  output logic             ldreg_n,
  output logic             lddacs_n,
  output logic             rst_out_n,
  output logic             rstsel
);

  localparam logic [CNT_W-1:0] V_LOW0  = CNT_W'(LOW0_C - 1);
  localparam logic [CNT_W-1:0] V_LOW   = CNT_W'(LOW_C - 1);
  localparam logic [CNT_W-1:0] V_HIGH  = CNT_W'(HIGH_C - 1);
  localparam logic [CNT_W-1:0] V_HIGHL = CNT_W'(HIGHL_C - 1);
  localparam logic [CNT_W-1:0] V_LDRW  = CNT_W'(LDRW_C - 1);
  localparam logic [CNT_W-1:0] V_LDDW  = CNT_W'(LDDW_C - 1);
  localparam logic [CNT_W-1:0] V_RSSH  = CNT_W'(RSSH_C - 1);
  localparam logic [CNT_W-1:0] V_RSTW  = CNT_W'(RSTW_C - 1);
  localparam logic [CNT_W-1:0] V_REC   = CNT_W'(REC_C - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  qdac_state_e      state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             upd_q, upd_d;
  logic             ready_q, ready_d;
  logic             cs_q, cs_d;
  logic             sclk_q, sclk_d;
  logic             ldreg_q, ldreg_d;
  logic             lddacs_q, lddacs_d;
  logic             rst_q, rst_d;
  logic             sel_q, sel_d;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    upd_d    = upd_q;
    ready_d  = ready_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    ldreg_d  = ldreg_q;
    lddacs_d = lddacs_q;
    rst_d    = rst_q;
    sel_d    = sel_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;

    case (state_q)
      ST_IDLE: begin
        ready_d = 1'b1;
        if (ready_q && cmd_valid) begin
          ready_d  = 1'b0;
          sel_d    = cmd_mid;
          tmr_load = 1'b1;
          tmr_val  = V_RSSH;
          state_d  = ST_SEL;
        end else if (ready_q && req_valid) begin
          ready_d  = 1'b0;
          sh_load  = 1'b1;
          upd_d    = req_update;
          cs_d     = 1'b0;
          sclk_d   = 1'b0;
          bit_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = V_LOW0;
          state_d  = ST_LOW;
        end
      end

      ST_LOW: begin
        if (tmr_zero) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = (bit_q == LAST_BIT) ? V_HIGHL : V_HIGH;
          state_d  = ST_HIGH;
        end
      end

      ST_HIGH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            cs_d    = 1'b1;
            ldreg_d = 1'b0;
            tmr_val = V_LDRW;
            state_d = ST_LDREG;
          end else begin
            sclk_d   = 1'b0;
            sh_shift = 1'b1;
            bit_d    = bit_q + 1'b1;
            tmr_val  = V_LOW;
            state_d  = ST_LOW;
          end
        end
      end

      ST_LDREG: begin
        if (tmr_zero) begin
          ldreg_d  = 1'b1;
          tmr_load = 1'b1;
          if (upd_q) begin
            lddacs_d = 1'b0;
            tmr_val  = V_LDDW;
            state_d  = ST_LDDACS;
          end else begin
            tmr_val  = V_REC;
            state_d  = ST_REC;
          end
        end
      end

      ST_LDDACS: begin
        if (tmr_zero) begin
          lddacs_d = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = V_REC;
          state_d  = ST_REC;
        end
      end

      ST_SEL: begin
        if (tmr_zero) begin
          rst_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = V_RSTW;
          state_d  = ST_RST;
        end
      end

      ST_RST: begin
        if (tmr_zero) begin
          rst_d    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = V_REC;
          state_d  = ST_REC;
        end
      end

      ST_REC: begin
        if (tmr_zero) begin
          ready_d = 1'b1;
          state_d = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      upd_q    <= 1'b0;
      ready_q  <= 1'b0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      ldreg_q  <= 1'b1;
      lddacs_q <= 1'b1;
      rst_q    <= 1'b1;
      sel_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      upd_q    <= upd_d;
      ready_q  <= ready_d;
      cs_q     <= cs_d;
      sclk_q   <= sclk_d;
      ldreg_q  <= ldreg_d;
      lddacs_q <= lddacs_d;
      rst_q    <= rst_d;
      sel_q    <= sel_d;
    end
  end

  assign ready     = ready_q;
  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign ldreg_n   = ldreg_q;
  assign lddacs_n  = lddacs_q;
  assign rst_out_n = rst_q;
  assign rstsel    = sel_q;

endmodule

// File: rtl/qdac_host_ctrl.sv
module qdac_host_ctrl
  import qdac_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int N_CH          = 4,
  parameter int CODE_W        = 12,
  parameter int PAD_W         = 2,
  parameter int CSS_NS        = 55,
  parameter int CSH_NS        = 15,
  parameter int CLKH_NS       = 30,
  parameter int CLKL_NS       = 50,
  parameter int DSU_NS        = 25,
  parameter int DHD_NS        = 20,
  parameter int LDSU_NS       = 40,
  parameter int LDHD_NS       = 15,
  parameter int LDW_NS        = 45,
  parameter int UPDW_NS       = 45,
  parameter int SELSU_NS      = 25,
  parameter int RSTW_NS       = 70,
  parameter int REC_NS        = 45,
  localparam int ADDR_W       = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_update,
  input  logic              rst_cmd_valid,
  input  logic              rst_cmd_mid,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_ldreg_n,
  output logic              dac_lddacs_n,
  output logic              dac_rst_n,
  output logic              dac_rstsel
);

  localparam int P       = CLK_PERIOD_NS;
  localparam int WORD_W  = ADDR_W + PAD_W + CODE_W;
  localparam int LOW_C   = imax(cyc_of(CLKL_NS, P), cyc_of(DSU_NS, P));
  localparam int LOW0_C  = imax(LOW_C, cyc_of(CSS_NS, P));
  localparam int HIGH_C  = imax(cyc_of(CLKH_NS, P), cyc_of(DHD_NS, P));
  localparam int HIGHL_C = imax(HIGH_C, imax(cyc_of(CSH_NS, P), cyc_of(LDHD_NS, P)));
  localparam int LDRW_C  = cyc_of(LDW_NS, P);
  localparam int LDDW_C  = cyc_of(UPDW_NS, P);
  localparam int RSSH_C  = cyc_of(SELSU_NS, P);
  localparam int RSTW_C  = cyc_of(RSTW_NS, P);
  localparam int REC_C   = imax(cyc_of(REC_NS, P), cyc_of(LDSU_NS, P));
  localparam int MAX_C   = imax(imax(imax(LOW0_C, HIGHL_C), imax(LDRW_C, LDDW_C)),
                                imax(imax(RSSH_C, RSTW_C), REC_C));
  localparam int CNT_W   = imax(1, $clog2(MAX_C + 1));

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic [WORD_W-1:0] word;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              sh_load;
  logic              sh_shift;

  qdac_fmt #(
    .ADDR_W (ADDR_W),
    .PAD_W  (PAD_W),
    .CODE_W (CODE_W)
  ) u_fmt (
    .chan (req_chan),
    .code (req_code),
    .word (word)
  );

  qdac_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_ns),
    .load  (sh_load),
    .din   (word),
    .shift (sh_shift),
    .msb   (dac_sdi)
  );

  qdac_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_ns),
    .load  (tmr_load),
    .val   (tmr_val),
    .zero  (tmr_zero)
  );

  qdac_seq #(
    .WORD_W  (WORD_W),
    .CNT_W   (CNT_W),
    .LOW0_C  (LOW0_C),
    .LOW_C   (LOW_C),
    .HIGH_C  (HIGH_C),
    .HIGHL_C (HIGHL_C),
    .LDRW_C  (LDRW_C),
    .LDDW_C  (LDDW_C),
    .RSSH_C  (RSSH_C),
    .RSTW_C  (RSTW_C),
    .REC_C   (REC_C)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_ns),
    .req_valid  (req_valid),
    .req_update (req_update),
    .cmd_valid  (rst_cmd_valid),
    .cmd_mid    (rst_cmd_mid),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .sh_load    (sh_load),
    .sh_shift   (sh_shift),
    .ready      (req_ready),
    .cs_n       (dac_cs_n),
    .sclk       (dac_sclk),
    .ldreg_n    (dac_ldreg_n),
    .lddacs_n   (dac_lddacs_n),
    .rst_out_n  (dac_rst_n),
    .rstsel     (dac_rstsel)
  );

endmodule

// File: rtl/qdac_chk.sv
module qdac_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic rst_cmd_valid,
  input logic req_ready,
  input logic cs_n,
  input logic sclk,
  input logic sdi,
  input logic ldreg_n,
  input logic lddacs_n,
  input logic dac_rst_n,
  input logic rstsel
);

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && sclk && ldreg_n && lddacs_n && dac_rst_n));

  a_r3_sdi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdi));

  a_r4_cs_rise_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sclk && $past(sclk)));

  a_r5_ldreg_quiet_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !ldreg_n |-> (sclk && cs_n && $stable(sclk)));

  a_r7_update_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !lddacs_n |-> (ldreg_n && cs_n && dac_rst_n));

  a_r8_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_rst_n |-> ($stable(rstsel) && cs_n && ldreg_n && lddacs_n));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid || rst_cmd_valid) && req_ready) |=> !req_ready);

endmodule

bind qdac_host_ctrl qdac_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_ns),
  .req_valid     (req_valid),
  .rst_cmd_valid (rst_cmd_valid),
  .req_ready     (req_ready),
  .cs_n          (dac_cs_n),
  .sclk          (dac_sclk),
  .sdi           (dac_sdi),
  .ldreg_n       (dac_ldreg_n),
  .lddacs_n      (dac_lddacs_n),
  .dac_rst_n     (dac_rst_n),
  .rstsel        (dac_rstsel)
);

// File: tb/sim_qdac_host_ctrl.sv
module sim_qdac_host_ctrl;

  localparam int P = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_LOWMIN  = (((50 + P - 1) / P) > ((25 + P - 1) / P)) ? ((50 + P - 1) / P) : ((25 + P - 1) / P);

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_chan;
  logic [11:0] req_code;
  logic        req_update;
  logic        rst_cmd_valid;
  logic        rst_cmd_mid;
  logic        dac_cs_n, dac_sclk, dac_sdi, dac_ldreg_n, dac_lddacs_n, dac_rst_n, dac_rstsel;

  qdac_host_ctrl #(.CLK_PERIOD_NS(P)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_chan      (req_chan),
    .req_code      (req_code),
    .req_update    (req_update),
    .rst_cmd_valid (rst_cmd_valid),
    .rst_cmd_mid   (rst_cmd_mid),
    .dac_cs_n      (dac_cs_n),
    .dac_sclk      (dac_sclk),
    .dac_sdi       (dac_sdi),
    .dac_ldreg_n   (dac_ldreg_n),
    .dac_lddacs_n  (dac_lddacs_n),
    .dac_rst_n     (dac_rst_n),
    .dac_rstsel    (dac_rstsel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected >= %0d", tag, act, lim);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // pin-level model of the converter registers
  int  mdl_in[4];
  int  mdl_dac[4];
  int  exp_in[4];
  int  exp_dac[4];
  int  upd_falls = 0;
  int  rst_falls = 0;
  bit  mon_en = 0;
  int  nbits = 0;
  logic [15:0] rx;
  logic p_sclk, p_sdi, p_cs, p_ld, p_upd, p_rst, p_sel, p_rdy;
  int sclk_age = 1000, sdi_age = 1000, cs_age = 1000, ld_age = 1000;
  int upd_age = 1000, rst_age = 1000, sel_age = 1000, strobe_age = 1000, since_rise = 1000;

  always @(negedge clk) begin
    if (mon_en) begin
      sclk_age++; sdi_age++; cs_age++; ld_age++; upd_age++;
      rst_age++; sel_age++; strobe_age++; since_rise++;

      if (dac_sclk !== p_sclk) begin
        chk_eq("R5 register-load high while clocking", int'(dac_ldreg_n), 1);
        if (dac_sclk) begin
          chk_ge("R3 clock low phase", sclk_age, C_LOWMIN);
          chk_ge("R3 data setup", sdi_age, cyc(25));
          chk_ge("R5 register-load high before rise", ld_age, cyc(40));
          if (!dac_cs_n) begin
            if (nbits == 0) chk_ge("R4 select setup", cs_age, cyc(55));
            rx = {rx[14:0], dac_sdi};
            nbits++;
          end
          since_rise = 0;
        end else begin
          chk_ge("R3 clock high phase", sclk_age, mx(cyc(30), cyc(20)));
        end
        sclk_age = 0;
      end

      if (dac_sdi !== p_sdi) begin
        chk_eq("R3 data moves only with clock low", int'(dac_sclk), 0);
        chk_ge("R3 data hold", since_rise, cyc(20));
        sdi_age = 0;
      end

      if (dac_cs_n !== p_cs) begin
        if (dac_cs_n) begin
          chk_eq("R4 select rises with clock high", int'(dac_sclk), 1);
          chk_ge("R4 select hold", since_rise, cyc(15));
          chk_eq("R2 bits per frame", nbits, 16);
        end else begin
          nbits = 0;
          chk_eq("R9 ready low while selected", int'(req_ready), 0);
        end
        cs_age = 0;
      end

      if (dac_ldreg_n !== p_ld) begin
        if (!dac_ldreg_n) begin
          chk_eq("R5 register-load with select high", int'(dac_cs_n), 1);
          chk_ge("R5 register-load after last rise", since_rise, cyc(15));
          chk_eq("R2 pad bits zero", int'(rx[13:12]), 0);
          mdl_in[rx[15:14]] = int'(rx[11:0]);
        end else begin
          chk_ge("R5 register-load width", ld_age, cyc(45));
          strobe_age = 0;
        end
        ld_age = 0;
      end

      if (dac_lddacs_n !== p_upd) begin
        if (!dac_lddacs_n) begin
          for (int c = 0; c < 4; c++) mdl_dac[c] = mdl_in[c];
          upd_falls++;
        end else begin
          chk_ge("R7 update-all width", upd_age, cyc(45));
          strobe_age = 0;
        end
        upd_age = 0;
      end

      if (dac_rstsel !== p_sel) begin
        chk_eq("R8 select moves with reset high", int'(dac_rst_n), 1);
        sel_age = 0;
      end

      if (dac_rst_n !== p_rst) begin
        if (!dac_rst_n) begin
          chk_ge("R8 select setup before reset", sel_age, cyc(25));
          for (int c = 0; c < 4; c++) begin
            mdl_in[c]  = dac_rstsel ? 2048 : 0;
            mdl_dac[c] = dac_rstsel ? 2048 : 0;
          end
          rst_falls++;
        end else begin
          chk_ge("R8 reset width", rst_age, cyc(70));
          strobe_age = 0;
        end
        rst_age = 0;
      end

      if (req_ready && !p_rdy)
        chk_ge("R10 recovery before ready", strobe_age, mx(cyc(45), cyc(40)));
    end
    p_sclk = dac_sclk; p_sdi = dac_sdi; p_cs = dac_cs_n; p_ld = dac_ldreg_n;
    p_upd = dac_lddacs_n; p_rst = dac_rst_n; p_sel = dac_rstsel; p_rdy = req_ready;
  end

  task automatic do_write(input int ch, input int code, input bit upd);
    int falls0;
    falls0 = upd_falls;
    @(negedge clk);
    req_chan = 2'(ch); req_code = 12'(code); req_update = upd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R9 ready drops after accept", int'(req_ready), 0);
    exp_in[ch] = code;
    if (upd) for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    while (!req_ready) @(negedge clk);
    chk_eq("R2 frame content in input register", mdl_in[ch], code);
    if (upd) begin
      chk_eq("R7 one update-all pulse", upd_falls - falls0, 1);
      for (int c = 0; c < 4; c++) chk_eq("R7 outputs after update", mdl_dac[c], exp_dac[c]);
    end else begin
      chk_eq("R6 no update-all pulse", upd_falls - falls0, 0);
      for (int c = 0; c < 4; c++) chk_eq("R6 outputs held", mdl_dac[c], exp_dac[c]);
    end
  endtask

  task automatic do_reset(input bit mid);
    int r0;
    r0 = rst_falls;
    @(negedge clk);
    rst_cmd_mid = mid; rst_cmd_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    rst_cmd_valid = 1'b0;
    for (int c = 0; c < 4; c++) begin
      exp_in[c]  = mid ? 2048 : 0;
      exp_dac[c] = mid ? 2048 : 0;
    end
    while (!req_ready) @(negedge clk);
    chk_eq("R8 one reset pulse", rst_falls - r0, 1);
    chk_eq("R8 select level", int'(dac_rstsel), int'(mid));
    for (int c = 0; c < 4; c++) begin
      chk_eq("R8 input register reset code", mdl_in[c], exp_in[c]);
      chk_eq("R8 output reset code", mdl_dac[c], exp_dac[c]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed;
    int r0;
    seed = 32'h1d5e;
    void'($urandom(seed));
    for (int c = 0; c < 4; c++) begin
      mdl_in[c] = 0; mdl_dac[c] = 0; exp_in[c] = 0; exp_dac[c] = 0;
    end
    rx = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_chan = '0; req_code = '0; req_update = 1'b0;
    rst_cmd_valid = 1'b0; rst_cmd_mid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_eq("R1 select idle high", int'(dac_cs_n), 1);
    chk_eq("R1 clock idle high", int'(dac_sclk), 1);
    chk_eq("R1 register-load idle high", int'(dac_ldreg_n), 1);
    chk_eq("R1 update-all idle high", int'(dac_lddacs_n), 1);
    chk_eq("R1 reset idle high", int'(dac_rst_n), 1);
    chk_eq("R1 ready after reset", int'(req_ready), 1);
    mon_en = 1;

    // R8 both scales
    do_reset(1'b0);
    do_reset(1'b1);

    // R2 extreme codes and channels
    do_write(0, 0, 1'b1);
    do_write(3, 4095, 1'b1);
    do_write(1, 12'h555, 1'b1);
    do_write(2, 12'hAAA, 1'b1);

    // R6 / R7 batch of four then one update
    do_write(0, 12'h123, 1'b0);
    do_write(1, 12'h456, 1'b0);
    do_write(2, 12'h789, 1'b0);
    do_write(3, 12'hABC, 1'b0);
    do_write(1, 12'hFED, 1'b1);

    // R9 priority: both valid together, reset goes first
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rst_falls;
    req_chan = 2'd2; req_code = 12'h0F0; req_update = 1'b1; req_valid = 1'b1;
    rst_cmd_mid = 1'b0; rst_cmd_valid = 1'b1;
    @(negedge clk);
    rst_cmd_valid = 1'b0;
    chk_eq("R9 write waits behind reset", int'(dac_cs_n), 1);
    chk_eq("R9 reset select taken", int'(dac_rstsel), 0);
    while (!req_ready) @(negedge clk);
    chk_eq("R9 reset done first", rst_falls - r0, 1);
    chk_eq("R9 write not yet framed", mdl_dac[2], 0);
    for (int c = 0; c < 4; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
    @(negedge clk);
    req_valid = 1'b0;
    exp_in[2] = 12'h0F0;
    for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    while (!req_ready) @(negedge clk);
    chk_eq("R9 queued write lands after reset", mdl_dac[2], 12'h0F0);

    // random mix
    for (int i = 0; i < 50; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 0) do_reset(1'($urandom_range(0, 1)));
      else do_write(int'($urandom_range(0, 3)), int'($urandom_range(0, 4095)), (k < 4));
    end

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule